// File: doc/BRIEF.md
# Serial EEPROM Target Model

This block answers a host over a mode-0 serial peripheral interface as a small byte-addressed nonvolatile memory would. The first byte of every chip-select frame is a command. The host can set and clear a write-enable latch, read or write a status byte, read a stream of bytes from any address, or write a run of bytes into a single page. Storage is an on-chip byte array that comes out of reset erased to 0xFF. The array size, page size, number of address bytes and the length of the simulated program cycle are all parameters.

All logic runs on a system clock that oversamples the serial clock, chip select and data-in. Input data is taken on the serial clock's rising edge and output data changes on its falling edge. Address bytes arrive most significant first. In the one-address-byte configuration, a parameter can let opcode bit 3 supply address bit 8, so that 512 bytes are reachable. Written bytes gather in a page buffer. They reach the array only when chip select rises on a whole-byte boundary. A busy flag then stays up for a fixed number of system clocks, and the host polls for it through the status command.

Top module: `serial_nvm_target`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it, both taking effect at the end of the opcode byte.
- R2: Opcode 0x05 returns the status byte: bit 0 busy, bit 1 write enable, bits 3:2 and bit 7 as last stored, bits 6:4 zero. The byte repeats, refreshed, for every further byte clocked while chip select stays low.
- R3: Opcode 0x03 followed by the address bytes (most significant first) streams the byte at that address and then at each following address for as long as chip select stays low, wrapping from the top of the array to address 0.
- R4: With one address byte and the opcode-extension parameter set, opcode bit 3 (values 0x0B and 0x0A) supplies address bit 8 for reads and writes, and opcodes 0x03 and 0x02 address bytes 0 to 255.
- R5: Opcode 0x02 and opcode 0x01 are ignored when the write-enable latch is clear: no busy period starts and the array and status are unchanged.
- R6: The data bytes of a write land at consecutive addresses whose offset within the page wraps to the page start. The page number never changes, and a later byte at the same offset replaces an earlier one.
- R7: Written data reaches the array only when chip select rises after a whole number of data bytes. A rise in the middle of a byte discards the whole frame, starts no busy period and leaves the write-enable latch set.
- R8: An accepted write with at least one data byte, or an accepted status write, sets the busy flag for BUSY_CLKS system clocks after chip select rises. When the busy flag drops, the write-enable latch clears.
- R9: While busy, every opcode other than 0x05 is ignored for the rest of its frame: MISO stays low and nothing is stored.
- R10: An accepted status write stores data bits 7, 3 and 2 as status bits 7, 3 and 2. Data bits 6:4 and 1:0 have no effect.
- R11: MISO is low while chip select is high and during every bit that carries no read data.
- R12: After reset the status byte is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host, idles low |
| csN | input | 1 | Active-low chip select, frames each command |
| mosi | input | 1 | Serial data from the host, sampled on sck rising |
| miso | output | 1 | Serial data to the host, changes on sck falling |

## Verification
The bench writes across the end of a page and reads the whole page back. A design that carried the address into the next page would corrupt the page above and leave the two wrapped bytes missing. It cuts a frame four bits into a data byte and checks that the target byte stays erased and the write-enable latch stays set; a design that committed early or started a busy period would fail both. It sends a write and a read inside the busy window and expects nothing stored and a silent MISO. It also reaches addresses 256 and above through opcode bit 3 and reads across the top of the array. A design that dropped the extra address bit would return the lower half's data, and one that wrapped wrongly would stream erased bytes where written data should appear.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;

  typedef struct packed {
    logic loadMem;   // prefetch array byte at memAddr for the next output byte
    logic loadStat;  // prefetch status byte for the next output byte
    logic bufClear;  // empty the page buffer
    logic bufPut;    // store received byte at page offset of memAddr
    logic commit;    // copy valid page buffer bytes into the array page
  } strobe_t;
endpackage

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = $clog2(MEM_BYTES),
  parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        statWord,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              csRise,
  output logic              csAligned
);
  logic       sckQ, csQ;
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic [7:0] txShift, txNext;
  logic       txPend;
  logic       sckRise, sckFall;

  logic [7:0] mem     [MEM_BYTES];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;

  assign sckRise   = sck & ~sckQ & ~csN;
  assign sckFall   = ~sck & sckQ & ~csN;
  assign byteDone  = sckRise && (bitCnt == 3'd7);
  assign rxByte    = {rxShift, mosi};
  assign csRise    = csN & ~csQ;
  assign csAligned = (bitCnt == 3'd0);
  assign miso      = txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ    <= 1'b0;
      csQ     <= 1'b1;
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
      if (csN) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        rxShift <= rxByte[6:0];
        bitCnt  <= bitCnt + 3'd1;
      end
    end
  end

  // Output byte is prefetched at the rising edge that ends a byte and
  // presented at the falling edge that follows it.
  always_ff @(posedge clk) begin
    if (!rstN || csN) begin
      txShift <= '0;
      txNext  <= '0;
      txPend  <= 1'b0;
    end else begin
      if (stb.loadMem) begin
        txNext <= mem[memAddr];
        txPend <= 1'b1;
      end else if (stb.loadStat) begin
        txNext <= statWord;
        txPend <= 1'b1;
      end
      if (sckFall) begin
        if (txPend) begin
          txShift <= txNext;
          txPend  <= 1'b0;
        end else begin
          txShift <= {txShift[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'h00;
      pageVld <= '0;
    end else begin
      if (stb.bufClear) pageVld <= '0;
      if (stb.bufPut) begin
        pageBuf[memAddr[OFS_W-1:0]] <= rxByte;
        pageVld[memAddr[OFS_W-1:0]] <= 1'b1;
      end
      if (stb.commit) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (pageVld[i]) mem[{memAddr[ADDR_W-1:OFS_W], OFS_W'(i)}] <= pageBuf[i];
      end
    end
  end
endmodule

// File: rtl/nvm_control.sv
module nvm_control
  import nvm_pkg::*;
#(
  parameter int ADDR_BYTES = 1,
  parameter bit OPCODE_A8  = 1'b1,
  parameter int ADDR_W     = 9,
  parameter int OFS_W      = 4,
  parameter int BUSY_CLKS  = 1000,
  localparam int BUSY_W    = $clog2(BUSY_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              byteDone,
  input  logic [7:0]        rxByte,
  input  logic              csRise,
  input  logic              csAligned,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        statWord
);
  typedef enum logic [2:0] {
    S_OP, S_ADDR, S_RD, S_WR, S_SWR, S_RDSR, S_SKIP
  } state_t;

  state_t            state;
  logic [1:0]        addrCnt;
  logic [15:0]       addrAcc;
  logic              hiBit, isRead, gotData, statHave;
  logic [2:0]        statPend;
  logic [ADDR_W-1:0] curAddr;
  logic              wel, wpen;
  logic [1:0]        bp;
  logic [BUSY_W-1:0] busyCnt;

  logic              busy, useHi, lastAddr, statCommit;
  logic [7:0]        opMasked, opCode;
  logic [ADDR_W-1:0] aNow, pageNext;

  assign busy     = (busyCnt != '0);
  assign statWord = {wpen, 3'b000, bp, wel, busy};
  assign opMasked = rxByte & 8'hF7;
  assign useHi    = OPCODE_A8 && (opMasked == OP_READ || opMasked == OP_WRITE);
  assign opCode   = useHi ? opMasked : rxByte;
  assign aNow     = ADDR_W'({addrAcc, rxByte} | (hiBit ? 24'h000100 : 24'h000000));
  assign pageNext = {curAddr[ADDR_W-1:OFS_W], curAddr[OFS_W-1:0] + OFS_W'(1)};
  assign lastAddr = (addrCnt == 2'd1);
  assign statCommit = csRise && csAligned && (state == S_SWR) && statHave;

  always_comb begin
    stb     = '0;
    memAddr = curAddr;
    if (byteDone) begin
      unique case (state)
        S_OP:   stb.loadStat = (opCode == OP_RD_STAT);
        S_ADDR: if (lastAddr) begin
          memAddr = aNow;
          if (isRead) stb.loadMem = 1'b1;
          else        stb.bufClear = 1'b1;
        end
        S_RD:   stb.loadMem  = 1'b1;
        S_RDSR: stb.loadStat = 1'b1;
        S_WR:   stb.bufPut   = 1'b1;
        default: ;
      endcase
    end
    if (csRise && csAligned && state == S_WR && gotData) stb.commit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_OP;
      addrCnt  <= '0;
      addrAcc  <= '0;
      hiBit    <= 1'b0;
      isRead   <= 1'b0;
      gotData  <= 1'b0;
      statHave <= 1'b0;
      statPend <= '0;
      curAddr  <= '0;
      wel      <= 1'b0;
      wpen     <= 1'b0;
      bp       <= '0;
      busyCnt  <= '0;
    end else begin
      if (busy) begin
        busyCnt <= busyCnt - BUSY_W'(1);
        if (busyCnt == BUSY_W'(1)) wel <= 1'b0;
      end
      if (stb.commit) busyCnt <= BUSY_W'(BUSY_CLKS);
      if (statCommit) begin
        wpen    <= statPend[2];
        bp      <= statPend[1:0];
        busyCnt <= BUSY_W'(BUSY_CLKS);
      end
      if (csN) begin
        state <= S_OP;
      end else if (byteDone) begin
        unique case (state)
          S_OP: begin
            gotData  <= 1'b0;
            statHave <= 1'b0;
            addrAcc  <= '0;
            hiBit    <= useHi & rxByte[3];
            addrCnt  <= 2'(ADDR_BYTES);
            state    <= S_SKIP;
            if (!busy || opCode == OP_RD_STAT) begin
              unique case (opCode)
                OP_SET_WEL: wel <= 1'b1;
                OP_CLR_WEL: wel <= 1'b0;
                OP_RD_STAT: state <= S_RDSR;
                OP_WR_STAT: if (wel) state <= S_SWR;
                OP_READ:  begin isRead <= 1'b1; state <= S_ADDR; end
                OP_WRITE: if (wel) begin isRead <= 1'b0; state <= S_ADDR; end
                default: ;
              endcase
            end
          end
          S_ADDR: begin
            addrAcc <= {addrAcc[7:0], rxByte};
            addrCnt <= addrCnt - 2'd1;
            if (lastAddr) begin
              curAddr <= isRead ? aNow + ADDR_W'(1) : aNow;
              state   <= isRead ? S_RD : S_WR;
            end
          end
          S_RD: curAddr <= curAddr + ADDR_W'(1);
          S_WR: begin
            curAddr <= pageNext;
            gotData <= 1'b1;
          end
          S_SWR: if (!statHave) begin
            statPend <= {rxByte[7], rxByte[3:2]};
            statHave <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_nvm_target.sv
module serial_nvm_target
  import nvm_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_BYTES = 1,
  parameter bit OPCODE_A8  = 1'b1,
  parameter int BUSY_CLKS  = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic mosi,
  output logic miso
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int OFS_W  = $clog2(PAGE_BYTES);

  strobe_t           stb;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        statWord, rxByte;
  logic              byteDone, csRise, csAligned;

  nvm_datapath #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .stb(stb), .memAddr(memAddr), .statWord(statWord), .byteDone(byteDone),
    .rxByte(rxByte), .csRise(csRise), .csAligned(csAligned)
  );

  nvm_control #(
    .ADDR_BYTES(ADDR_BYTES), .OPCODE_A8(OPCODE_A8), .ADDR_W(ADDR_W),
    .OFS_W(OFS_W), .BUSY_CLKS(BUSY_CLKS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .csN(csN), .byteDone(byteDone), .rxByte(rxByte),
    .csRise(csRise), .csAligned(csAligned), .stb(stb), .memAddr(memAddr),
    .statWord(statWord)
  );
endmodule

// File: rtl/nvm_checker.sv
module nvm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       miso,
  input logic [7:0] statWord
);
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN && $past(csN) |-> !miso);                                    // R11
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statWord[0]) |-> $past(statWord[1]));                      // R5
  AST_BUSY_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statWord[0]) |-> $past(csN));                              // R7
  AST_WEL_DROPS_WITH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statWord[0]) |-> !statWord[1]);                            // R8
  AST_PROTECT_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statWord[7:2]) |-> $rose(statWord[0]));                 // R10
  AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    statWord[6:4] == 3'b000);                                        // R2
endmodule

bind serial_nvm_target nvm_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso), .statWord(statWord)
);

// File: tb/sim_serial_nvm_target.sv
`timescale 1ns/1ps
module sim_serial_nvm_target;
  localparam int BUSY = 1000;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso;
  always #2 clk = ~clk;  // 250 MHz

  serial_nvm_target #(
    .MEM_BYTES(512), .PAGE_BYTES(16), .ADDR_BYTES(1), .OPCODE_A8(1'b1), .BUSY_CLKS(BUSY)
  ) u0 (.clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso));

  int errors = 0, checks = 0;
  logic [7:0] model [512];
  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [7:0] lastRx;
  event       rxEv;
  bit         finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item for each observed byte
  initial forever begin
    @(rxEv);
    if (expQ.size() == 0) check(0, "monitor unexpected byte", lastRx, 0);
    else begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(lastRx == e, t, lastRx, e);
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic selectDev();
    @(negedge clk); csN = 1'b0; clks(2);
  endtask

  task automatic deselect();
    clks(2); csN = 1'b1; clks(4);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input bit watch);
    logic [7:0] rx;
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      clks(4);
      rx[i] = miso;
      sck = 1'b1;
      clks(4);
      sck = 1'b0;
    end
    if (watch) begin
      lastRx = rx;
      ->rxEv;
      clks(1);
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    selectDev(); xfer(op, 8, 0); deselect();
  endtask

  task automatic statChk(input string tag, input logic [7:0] exp, input int n);
    selectDev();
    xfer(8'h05, 8, 0);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(exp); tagQ.push_back(tag);
      xfer(8'h00, 8, 1);
    end
    deselect();
  endtask

  // Read n bytes; quiet means the opcode is expected to be ignored (MISO low)
  task automatic readChk(input string tag, input int addr, input int n, input bit quiet);
    selectDev();
    xfer(addr >= 256 ? 8'h0B : 8'h03, 8, 0);
    xfer(addr[7:0], 8, 0);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(quiet ? 8'h00 : model[(addr + i) % 512]);
      tagQ.push_back(tag);
      xfer(8'h00, 8, 1);
    end
    deselect();
  endtask

  task automatic writeN(input int addr, input int n, input logic [7:0] base, input bit accept);
    selectDev();
    xfer(addr >= 256 ? 8'h0A : 8'h02, 8, 0);
    xfer(addr[7:0], 8, 0);
    for (int i = 0; i < n; i++) begin
      xfer(base + 8'(i), 8, 0);
      if (accept) model[(addr & ~15) | ((addr + i) & 15)] = base + 8'(i);
    end
    deselect();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    clks(5); rstN = 1'b1; clks(3);

    check(miso == 1'b0, "R11 idle miso", miso, 0);
    statChk("R12 reset status", 8'h00, 1);
    readChk("R12 erased array", 0, 4, 0);

    cmd(8'h06); statChk("R1 latch set", 8'h02, 1);
    cmd(8'h04); statChk("R1 latch clear", 8'h00, 1);

    writeN(8'h05, 2, 8'hA0, 0);
    statChk("R5 no busy without latch", 8'h00, 1);
    readChk("R5 array untouched", 4, 4, 0);

    cmd(8'h06);
    writeN(8'h05, 3, 8'h10, 1);
    statChk("R8 busy with latch", 8'h03, 2);     // R2 repeated status
    writeN(8'h40, 1, 8'h55, 0);
    readChk("R9 read ignored while busy", 5, 2, 1);
    clks(BUSY + 50);
    statChk("R8 busy done latch cleared", 8'h00, 1);
    readChk("R3 stream read", 4, 5, 0);
    readChk("R9 busy write not stored", 8'h40, 1, 0);

    cmd(8'h06); writeN(8'h2E, 4, 8'h60, 1); clks(BUSY + 50);
    readChk("R6 page wrap", 8'h20, 17, 0);

    cmd(8'h06); writeN(9'h110, 2, 8'h70, 1); clks(BUSY + 50);
    readChk("R4 upper half via opcode bit", 9'h10F, 3, 0);
    readChk("R4 lower half untouched", 8'h10, 2, 0);

    cmd(8'h06); writeN(9'h1FF, 1, 8'h99, 1); clks(BUSY + 50);
    cmd(8'h06); writeN(9'h000, 1, 8'h3C, 1); clks(BUSY + 50);
    readChk("R3 read wraps top of array", 9'h1FE, 4, 0);

    cmd(8'h06);
    selectDev(); xfer(8'h02, 8, 0); xfer(8'h50, 8, 0); xfer(8'h12, 8, 0); xfer(8'h34, 4, 0); deselect();
    statChk("R7 partial byte no busy latch kept", 8'h02, 1);
    readChk("R7 partial frame discarded", 8'h50, 1, 0);
    cmd(8'h04);

    cmd(8'h06);
    selectDev(); xfer(8'h01, 8, 0); xfer(8'hFF, 8, 0); deselect();
    statChk("R10 status write busy", 8'h8F, 1);
    clks(BUSY + 50);
    statChk("R10 status bits stored", 8'h8C, 2);
    selectDev(); xfer(8'h01, 8, 0); xfer(8'h00, 8, 0); deselect();
    statChk("R5 status write needs latch", 8'h8C, 1);
    cmd(8'h06);
    selectDev(); xfer(8'h01, 8, 0); xfer(8'h00, 8, 0); deselect();
    clks(BUSY + 50);
    statChk("R10 status cleared", 8'h00, 1);
    check(miso == 1'b0, "R11 miso low after frames", miso, 0);

    clks(20);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule